// File: doc/BRIEF.md
# JK-Fed Parallel-Load Shift Register

This block is a small synchronous shift register, four bits wide by default, in which every stored change happens on the rising clock edge. At each edge it does one of two things. If the load enable is high it captures a parallel word. If the load enable is low it moves every bit one place toward the most significant position. When it shifts, bit 0 takes a new value from a J input and an active-low K input. Together these two inputs set, clear, hold or toggle the first stage.

A polarity select chooses what the parallel outputs show: either the stored bits or their inverses. The stored contents do not change when the polarity changes. An asynchronous clear input overrides clock, load and serial inputs and forces the stored word to zero for as long as it is high.

Typical uses are a serial-to-parallel converter with a preset word, and a small sequencer whose first stage is driven like a JK flip-flop.

Top module: `jkload_shreg`

## Requirements
- R1: While `clear_i` is high the stored word is all zeros, and it stays zero across clock edges. `q_o` is then all zeros when `true_sel_i` is 1 and all ones when it is 0.
- R2: `clear_i` acts without a clock edge: `q_o` reaches its cleared value as soon as `clear_i` rises, before the next rising edge.
- R3: With `load_en_i` high at a rising edge, the stored word becomes `par_i`. Bit i of `par_i` goes to bit i of the store.
- R4: With `load_en_i` low at a rising edge, stored bit i takes the previous stored bit i-1, for every i from 1 to WIDTH-1.
- R5: When shifting with `j_i`=0 and `k_n_i`=0, stored bit 0 becomes 0.
- R6: When shifting with `j_i`=1 and `k_n_i`=1, stored bit 0 becomes 1.
- R7: When shifting with `j_i`=0 and `k_n_i`=1, stored bit 0 keeps its previous value.
- R8: When shifting with `j_i`=1 and `k_n_i`=0, stored bit 0 becomes the inverse of its previous value.
- R9: `q_o` equals the stored word when `true_sel_i` is 1 and its bitwise inverse when `true_sel_i` is 0. A change of `true_sel_i` alone never alters the stored word.
- R10: A load ignores `j_i` and `k_n_i`: the loaded word equals `par_i` whatever the serial inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clear_i | input | 1 | Asynchronous clear, active high, highest priority |
| load_en_i | input | 1 | 1 = parallel load, 0 = shift up |
| par_i | input | WIDTH | Parallel load word |
| j_i | input | 1 | Serial J input to stage 0 |
| k_n_i | input | 1 | Serial K input to stage 0, active low |
| true_sel_i | input | 1 | 1 = true outputs, 0 = complemented outputs |
| q_o | output | WIDTH | Parallel outputs |

## Verification
Stage 0 is driven through all four J/K combinations, starting from both a 0 and a 1. This separates the hold case from the set and clear cases, and the toggle case from a stuck input. Loads use the alternating words 0101 and 1010 and the full word 1111, so that a swapped or dropped bit position shows up. Loads are also applied with each J/K setting to confirm that load wins over shift. Long shift runs check that every stage takes its lower neighbour's value. The polarity select is flipped both between operations and during clear. Clear is raised between clock edges, which shows that it acts without waiting for an edge.

// File: rtl/jkshr_pkg.sv
package jkshr_pkg;

    typedef enum logic [0:0] {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } jkshr_op_e;

    // Next value of the first stage from J, active-low K and its present value
    function automatic logic jk_next(input logic j, input logic k_n, input logic cur);
        return (j & ~cur) | (k_n & cur);
    endfunction

endpackage

// File: rtl/jkshr_first_stage.sv
module jkshr_first_stage
    import jkshr_pkg::*;
(
    input  logic j_i,
    input  logic k_n_i,
    input  logic cur_i,
    output logic nxt_o
);
    always_comb begin
        nxt_o = jk_next(j_i, k_n_i, cur_i);
    end
endmodule

// File: rtl/jkshr_polarity.sv
module jkshr_polarity #(
    parameter int WIDTH = 4
) (
    input  logic             true_sel_i,
    input  logic [WIDTH-1:0] store_i,
    output logic [WIDTH-1:0] q_o
);
    localparam logic [WIDTH-1:0] INV_MASK = {WIDTH{1'b1}};

    always_comb begin
        q_o = true_sel_i ? store_i : (store_i ^ INV_MASK);
    end
endmodule

// File: rtl/jkload_shreg.sv
module jkload_shreg
    import jkshr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_i,
    input  logic             load_en_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             j_i,
    input  logic             k_n_i,
    input  logic             true_sel_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shreg_state_t;

    shreg_state_t state_d, state_q;
    jkshr_op_e    op;
    logic         stage0_nxt;

    assign op = load_en_i ? OP_LOAD : OP_SHIFT;

    jkshr_first_stage u_first (
        .j_i   (j_i),
        .k_n_i (k_n_i),
        .cur_i (state_q.bits[0]),
        .nxt_o (stage0_nxt)
    );

    always_comb begin
        state_d = state_q;
        case (op)
            OP_LOAD:  state_d.bits = par_i;
            default:  state_d.bits = {state_q.bits[MSB-1:0], stage0_nxt};
        endcase
    end

    always_ff @(posedge clk or posedge clear_i) begin
        if (clear_i) state_q <= '0;
        else         state_q <= state_d;
    end

    jkshr_polarity #(.WIDTH(WIDTH)) u_pol (
        .true_sel_i (true_sel_i),
        .store_i    (state_q.bits),
        .q_o        (q_o)
    );

    // ---------------- assertions ----------------
    a_r1_clear_outputs: assert property (@(posedge clk)
        clear_i |-> (q_o == (true_sel_i ? '0 : {WIDTH{1'b1}})));

    a_r3_load_word: assert property (@(posedge clk) disable iff (clear_i)
        load_en_i |=> (state_q.bits == $past(par_i)));

    a_r4_shift_up: assert property (@(posedge clk) disable iff (clear_i)
        !load_en_i |=> (state_q.bits[MSB:1] == $past(state_q.bits[MSB-1:0])));

    a_r5_jk_clear: assert property (@(posedge clk) disable iff (clear_i)
        (!load_en_i && !j_i && !k_n_i) |=> !state_q.bits[0]);

    a_r6_jk_set: assert property (@(posedge clk) disable iff (clear_i)
        (!load_en_i && j_i && k_n_i) |=> state_q.bits[0]);

    a_r7_jk_hold: assert property (@(posedge clk) disable iff (clear_i)
        (!load_en_i && !j_i && k_n_i) |=> (state_q.bits[0] == $past(state_q.bits[0])));

    a_r8_jk_toggle: assert property (@(posedge clk) disable iff (clear_i)
        (!load_en_i && j_i && !k_n_i) |=> (state_q.bits[0] != $past(state_q.bits[0])));

    a_r9_polarity: assert property (@(posedge clk)
        (q_o ^ state_q.bits) == (true_sel_i ? '0 : {WIDTH{1'b1}}));

endmodule

// File: tb/jkload_shreg_tb_top.sv
`timescale 1ns/1ps
module jkload_shreg_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clear_i;
    logic         load_en_i;
    logic [W-1:0] par_i;
    logic         j_i, k_n_i, true_sel_i;
    logic [W-1:0] q_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] model;

    always #2.5 clk = ~clk;

    jkload_shreg #(.WIDTH(W)) dut_i (
        .clk(clk), .clear_i(clear_i), .load_en_i(load_en_i), .par_i(par_i),
        .j_i(j_i), .k_n_i(k_n_i), .true_sel_i(true_sel_i), .q_o(q_o)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] shown(input logic [W-1:0] s, input logic ts);
        return ts ? s : ~s;
    endfunction

    // Drive at negedge, clock, then sample 1 ns after the rising edge
    task automatic step(input logic ld, input logic [W-1:0] p, input logic j, input logic kn);
        logic b0;
        @(negedge clk);
        load_en_i = ld; par_i = p; j_i = j; k_n_i = kn;
        @(posedge clk);
        #1;
        if (ld) model = p;
        else begin
            if (!j && !kn)     b0 = 1'b0;
            else if (j && kn)  b0 = 1'b1;
            else if (!j && kn) b0 = model[0];
            else               b0 = ~model[0];
            model = {model[W-2:0], b0};
        end
    endtask

    task automatic t_reset;
        clear_i = 1'b1; true_sel_i = 1'b1;
        load_en_i = 1'b1; par_i = 4'b1111; j_i = 1'b1; k_n_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 clear true", q_o, 4'b0000);
        true_sel_i = 1'b0;
        #1 check("R1 clear complement", q_o, 4'b1111);
        @(negedge clk);
        clear_i = 1'b0; true_sel_i = 1'b1; model = '0;
    endtask

    task automatic t_load;
        step(1'b1, 4'b0101, 1'b0, 1'b0); check("R3 load 0101", q_o, model);
        step(1'b1, 4'b1010, 1'b1, 1'b1); check("R3 load 1010", q_o, 4'b1010);
        step(1'b1, 4'b1111, 1'b1, 1'b0); check("R10 load over toggle", q_o, 4'b1111);
        step(1'b1, 4'b0000, 1'b1, 1'b1); check("R10 load over set", q_o, 4'b0000);
    endtask

    task automatic t_jk;
        step(1'b1, 4'b0000, 1'b0, 1'b0);
        step(1'b0, 4'b1111, 1'b1, 1'b1); check("R6 set", q_o, 4'b0001);
        step(1'b0, 4'b0000, 1'b0, 1'b1); check("R7 hold one", q_o, 4'b0011);
        step(1'b0, 4'b0000, 1'b1, 1'b0); check("R8 toggle to zero", q_o, 4'b0110);
        step(1'b0, 4'b0000, 1'b0, 1'b1); check("R7 hold zero", q_o, 4'b1100);
        step(1'b0, 4'b0000, 1'b1, 1'b0); check("R8 toggle to one", q_o, 4'b1001);
        step(1'b0, 4'b1111, 1'b0, 1'b0); check("R5 clear stage", q_o, 4'b0010);
        step(1'b0, 4'b1111, 1'b0, 1'b0); check("R5 clear again", q_o, model);
    endtask

    task automatic t_shift_run;
        step(1'b1, 4'b1011, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 4'b0000, 1'b0, 1'b0);
            check("R4 shift run", q_o, model);
        end
        check("R4 shifted out", q_o, 4'b0000);
    endtask

    task automatic t_polarity;
        step(1'b1, 4'b0110, 1'b0, 1'b1);
        @(negedge clk); true_sel_i = 1'b0;
        #1 check("R9 complement", q_o, 4'b1001);
        @(negedge clk); true_sel_i = 1'b1;
        #1 check("R9 store kept", q_o, 4'b0110);
        @(negedge clk); true_sel_i = 1'b0;
        step(1'b0, 4'b0000, 1'b1, 1'b1);
        check("R9 shift in complement", q_o, shown(model, 1'b0));
        @(negedge clk); true_sel_i = 1'b1;
        #1 check("R9 true after shift", q_o, 4'b1101);
    endtask

    task automatic t_async;
        step(1'b1, 4'b1110, 1'b0, 1'b0);
        @(negedge clk); #0.5;
        clear_i = 1'b1;
        #0.5 check("R2 clear before edge", q_o, 4'b0000);
        @(negedge clk); clear_i = 1'b0; model = '0;
        #0.5 check("R1 held after clear", q_o, 4'b0000);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load();
                t_jk();
                t_shift_run();
                t_polarity();
                t_async();
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule